// File: doc/BRIEF.md
# Run-Length Sample Stream Expander

This block turns words read back from a logic-analyser capture memory into a plain stream of samples. The memory delivers 32-bit words grouped in slices of nine. The first eight words of a slice carry the low 32 bits of eight coded words. The ninth word packs the four missing high bits of each of those eight. The block gathers a whole slice, merges each coded word back to 36 bits and feeds it through a two-state run-length decoder. It then emits one 34-bit sample per output beat, using a valid/ready handshake on both sides.

A session opens with a one-cycle start pulse. The pulse loads the number of coded words to decode and the largest number of samples to emit. The input may pause at any point, including inside a slice or between slices. The decoder keeps its mode, held sample and pending run across such pauses and across slice boundaries, so a run-length word can sit in a different slice from the data word it extends. When the session is over, `done_o` rises and stays high until the next start.

Top module: `rle_slice_expander`

## Requirements
- R1: Input slice layout. Each slice is nine words. Words 0 to 7 give bits 31:0 of coded words 0 to 7. Word 8 gives their bits 35:32, with coded word k taking bits [31-4k:28-4k] of word 8.
- R2: A coded word decoded in data mode sets the held sample to its bits 33:0. That sample is emitted (bit 34 + 1) times.
- R3: A data-mode word with bit 35 set makes the next coded word a length word. The whole 36-bit length word, times two, is added to the pending run, and the decoder returns to data mode. No sample of that run is emitted before the length word has been applied.
- R4: The decoder mode, held sample and pending run carry across slice boundaries and across cycles with `in_valid_i` low.
- R5: Only the first `word_count_i` coded words of a session are decoded. Unused word positions in the last slice are accepted at the input but have no effect on the output.
- R6: A session emits at most `sample_limit_i` samples, cutting the final run short. A limit of 0 emits nothing.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value and no sample or run count is lost.
- R8: `out_data_o` is 40 bits. Byte i sits in bits 8i+7:8i, the least significant byte is byte 0, and bits 39:34 are zero.
- R9: A start pulse clears the decoder mode to data, clears the held sample, pending run and sample counter, and loads a new word count and limit.
- R10: `done_o` goes high once the limit is reached, or once all counted words are decoded and no data-mode run is pending. It stays high until the next start, and while it is high `out_valid_o` and `in_ready_o` are low.
- R11: After reset and before the first start, `in_ready_o`, `out_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a session |
| word_count_i | input | CNT_W (16) | Coded words to decode, sampled at start |
| sample_limit_i | input | LIM_W (32) | Largest sample count to emit, sampled at start |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | WORD_W (32) | Memory word, slice order |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts the sample |
| out_data_o | output | 40 | Sample as five bytes, least significant first |
| done_o | output | 1 | Session complete |

## Verification
The expander is driven with several word patterns:
- Single and doubled runs tell bit 34 apart from the plain one-sample case.
- A length word with a large high nibble shows that the merged bits 35:32 reach the run arithmetic.
- A data word ending one slice with its length word opening the next, run with input gaps and output stalls, separates state that is kept from state that is lost.
- Nonzero padding in the last slice tells the word count from the slice size.
- Limits of 0, 5 and 20 against longer streams show truncation inside a run.
- Back-to-back sessions, the first left waiting for a length word, show whether a start really clears the mode.

// File: rtl/rse_pkg.sv
package rse_pkg;
    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_LEN  = 1'b1
    } rle_mode_e;
endpackage

// File: rtl/rse_slice_gather.sv
module rse_slice_gather #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CNT_W-1:0]         count_i,
    input  logic                     freeze_i,
    input  logic                     in_valid_i,
    input  logic [WORD_W-1:0]        in_data_i,
    output logic                     in_ready_o,
    input  logic                     take_i,
    output logic                     code_valid_o,
    output logic [WORD_W+NIB_W-1:0]  code_o,
    output logic                     left_zero_o
);
    localparam int LANES  = WORD_W / NIB_W;
    localparam int SLOTS  = LANES + 1;
    localparam int CODE_W = WORD_W + NIB_W;
    localparam int FILL_W = $clog2(SLOTS + 1);
    localparam int RD_W   = $clog2(LANES + 1);
    localparam int IDX_W  = $clog2(LANES);

    typedef struct packed {
        logic                         busy;
        logic [FILL_W-1:0]            fill;
        logic [RD_W-1:0]              rd;
        logic [CNT_W-1:0]             left;
        logic [SLOTS-1:0][WORD_W-1:0] words;
    } gather_t;

    gather_t st_d, st_q;

    logic [LANES-1:0][CODE_W-1:0] lane_code;
    logic                         full;
    logic                         release_slice;
    logic [IDX_W-1:0]             rd_idx;

    // Merge the shared high-nibble word back onto each data word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_code[g] = {st_q.words[LANES][WORD_W-1-NIB_W*g -: NIB_W],
                               st_q.words[g]};
    end

    assign full          = (st_q.fill == FILL_W'(SLOTS));
    assign rd_idx        = st_q.rd[IDX_W-1:0];
    assign left_zero_o   = (st_q.left == '0);
    assign code_valid_o  = st_q.busy && full && (st_q.rd < RD_W'(LANES)) && !left_zero_o;
    assign code_o        = lane_code[rd_idx];
    assign release_slice = full && ((st_q.rd == RD_W'(LANES)) || left_zero_o);
    assign in_ready_o    = st_q.busy && !full && !left_zero_o && !freeze_i;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.left = count_i;
            st_d.fill = '0;
            st_d.rd   = '0;
        end else begin
            if (in_valid_i && in_ready_o) begin
                st_d.words[st_q.fill] = in_data_i;
                st_d.fill             = st_q.fill + FILL_W'(1);
            end
            if (take_i) begin
                st_d.rd   = st_q.rd + RD_W'(1);
                st_d.left = st_q.left - CNT_W'(1);
            end
            if (release_slice) begin
                st_d.fill = '0;
                st_d.rd   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rse_rle_core.sv
module rse_rle_core
    import rse_pkg::*;
#(
    parameter int CODE_W = 36,
    parameter int LIM_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [LIM_W-1:0]     limit_i,
    input  logic                 code_valid_i,
    input  logic [CODE_W-1:0]    code_i,
    input  logic                 words_done_i,
    output logic                 take_o,
    output logic                 out_valid_o,
    input  logic                 out_ready_i,
    output logic [CODE_W-3:0]    sample_o,
    output logic                 limit_hit_o,
    output logic                 done_o
);
    localparam int SAMPLE_W = CODE_W - 2;
    localparam int RUN_W    = CODE_W + 2;

    typedef struct packed {
        logic                active;
        rle_mode_e           mode;
        logic [SAMPLE_W-1:0] sample;
        logic [RUN_W-1:0]    run;
        logic [LIM_W-1:0]    emitted;
        logic [LIM_W-1:0]    limit;
    } core_t;

    core_t st_d, st_q;
    logic  run_live;
    logic  fire;

    assign limit_hit_o = st_q.active && (st_q.emitted >= st_q.limit);
    assign run_live    = (st_q.mode == MODE_DATA) && (st_q.run != '0);
    assign out_valid_o = st_q.active && run_live && !limit_hit_o;
    assign fire        = out_valid_o && out_ready_i;
    assign take_o      = st_q.active && !limit_hit_o && code_valid_i &&
                         ((st_q.mode == MODE_LEN) || (st_q.run == '0));
    assign sample_o    = st_q.sample;
    assign done_o      = st_q.active && (limit_hit_o || (words_done_i && !run_live));

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active  = 1'b1;
            st_d.mode    = MODE_DATA;
            st_d.sample  = '0;
            st_d.run     = '0;
            st_d.emitted = '0;
            st_d.limit   = limit_i;
        end else if (take_o) begin
            if (st_q.mode == MODE_DATA) begin
                st_d.sample = code_i[SAMPLE_W-1:0];
                st_d.run    = RUN_W'(code_i[SAMPLE_W]) + RUN_W'(1);
                st_d.mode   = code_i[SAMPLE_W+1] ? MODE_LEN : MODE_DATA;
            end else begin
                st_d.run  = st_q.run + RUN_W'({code_i, 1'b0});
                st_d.mode = MODE_DATA;
            end
        end else if (fire) begin
            st_d.run     = st_q.run - RUN_W'(1);
            st_d.emitted = st_q.emitted + LIM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rse_byte_lanes.sv
module rse_byte_lanes #(
    parameter int SAMPLE_W = 34
) (
    input  logic [SAMPLE_W-1:0]                sample_i,
    output logic [((SAMPLE_W+7)/8)*8-1:0]      bytes_o
);
    localparam int BYTES = (SAMPLE_W + 7) / 8;
    localparam int OUT_W = BYTES * 8;

    logic [OUT_W-1:0] padded;
    assign padded = OUT_W'(sample_i);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign bytes_o[8*b +: 8] = padded[8*b +: 8];
    end
endmodule

// File: rtl/rle_slice_expander.sv
module rle_slice_expander #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int CNT_W  = 16,
    parameter int LIM_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     word_count_i,
    input  logic [LIM_W-1:0]     sample_limit_i,
    input  logic                 in_valid_i,
    input  logic [WORD_W-1:0]    in_data_i,
    output logic                 in_ready_o,
    output logic                 out_valid_o,
    input  logic                 out_ready_i,
    output logic [39:0]          out_data_o,
    output logic                 done_o
);
    localparam int CODE_W   = WORD_W + NIB_W;
    localparam int SAMPLE_W = CODE_W - 2;

    logic                code_valid;
    logic [CODE_W-1:0]   code;
    logic                left_zero;
    logic                take;
    logic                limit_hit;
    logic [SAMPLE_W-1:0] sample;

    rse_slice_gather #(.WORD_W(WORD_W), .NIB_W(NIB_W), .CNT_W(CNT_W)) gather_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .count_i      (word_count_i),
        .freeze_i     (limit_hit),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .in_ready_o   (in_ready_o),
        .take_i       (take),
        .code_valid_o (code_valid),
        .code_o       (code),
        .left_zero_o  (left_zero)
    );

    rse_rle_core #(.CODE_W(CODE_W), .LIM_W(LIM_W)) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .limit_i      (sample_limit_i),
        .code_valid_i (code_valid),
        .code_i       (code),
        .words_done_i (left_zero),
        .take_o       (take),
        .out_valid_o  (out_valid_o),
        .out_ready_i  (out_ready_i),
        .sample_o     (sample),
        .limit_hit_o  (limit_hit),
        .done_o       (done_o)
    );

    rse_byte_lanes #(.SAMPLE_W(SAMPLE_W)) lanes_i (
        .sample_i (sample),
        .bytes_o  (out_data_o)
    );
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
    parameter int LIM_W    = 32,
    parameter int SAMPLE_W = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LIM_W-1:0] sample_limit_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [39:0]      out_data_o,
    input logic             done_o
);
    logic [LIM_W:0]   fires_q;
    logic [LIM_W-1:0] lim_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fires_q <= '0;
            lim_q   <= '0;
            seen_q  <= 1'b0;
        end else if (start_i) begin
            fires_q <= '0;
            lim_q   <= sample_limit_i;
            seen_q  <= 1'b1;
        end else if (out_valid_o && out_ready_i) begin
            fires_q <= fires_q + (LIM_W+1)'(1);
        end
    end

    p_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fires_q <= {1'b0, lim_q});

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_data_o[39:SAMPLE_W] == '0));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !out_valid_o);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!out_valid_o && !in_ready_o));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!in_ready_o && !out_valid_o && !done_o));
endmodule

bind rle_slice_expander rse_checker #(.LIM_W(LIM_W), .SAMPLE_W(SAMPLE_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sample_limit_i (sample_limit_i),
    .in_ready_o     (in_ready_o),
    .out_valid_o    (out_valid_o),
    .out_ready_i    (out_ready_i),
    .out_data_o     (out_data_o),
    .done_o         (done_o)
);

// File: tb/rle_slice_expander_tb_top.sv
module rle_slice_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] word_count_i = '0;
    logic [31:0] sample_limit_i = '0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_data_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [39:0] out_data_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int total_cycles = 0;
    logic [33:0] exp_q [256];

    always #2 clk = ~clk;

    rle_slice_expander dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .word_count_i(word_count_i), .sample_limit_i(sample_limit_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_data_o(out_data_o), .done_o(done_o)
    );

    // Row: pattern id, word count, limit, input gaps, output stalls, expected samples
    typedef struct packed {
        logic [7:0]  id;
        logic [15:0] count;
        logic [31:0] limit;
        logic        gap;
        logic        bp;
        logic [15:0] exp_n;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{id: 8'd0, count: 16'd4,  limit: 32'd100,  gap: 1'b0, bp: 1'b0, exp_n: 16'd10}, // R1 R2 R3
        '{id: 8'd1, count: 16'd10, limit: 32'd1000, gap: 1'b0, bp: 1'b0, exp_n: 16'd17}, // R4 R5
        '{id: 8'd0, count: 16'd4,  limit: 32'd5,    gap: 1'b0, bp: 1'b0, exp_n: 16'd5},  // R6 cut
        '{id: 8'd0, count: 16'd4,  limit: 32'd0,    gap: 1'b0, bp: 1'b0, exp_n: 16'd0},  // R6 zero
        '{id: 8'd1, count: 16'd10, limit: 32'd1000, gap: 1'b1, bp: 1'b1, exp_n: 16'd17}, // R7 R4
        '{id: 8'd2, count: 16'd2,  limit: 32'd20,   gap: 1'b0, bp: 1'b1, exp_n: 16'd20}, // R3 R6
        '{id: 8'd3, count: 16'd1,  limit: 32'd10,   gap: 1'b0, bp: 1'b0, exp_n: 16'd0},  // R9 leaves length pending
        '{id: 8'd4, count: 16'd1,  limit: 32'd10,   gap: 1'b0, bp: 1'b0, exp_n: 16'd1}   // R9 fresh data mode
    };

    function automatic logic [35:0] dword(logic [33:0] s, logic b34, logic b35);
        return {b35, b34, s};
    endfunction

    function automatic logic [35:0] build(int id, int k);
        logic [35:0] pad = 36'hF_FFFF_FFFF;
        case (id)
            0: case (k)
                   0: return dword(34'h3_0000_0011, 1'b0, 1'b0);
                   1: return dword(34'h2_1234_5678, 1'b1, 1'b0);
                   2: return dword(34'h1_ABCD_0001, 1'b0, 1'b1);
                   3: return 36'd3;
                   default: return pad;
               endcase
            1: begin
                if (k < 7) return dword({2'(k), 32'h0101_0101 * 32'(k)}, 1'(k % 2), 1'b0);
                if (k == 7) return dword(34'h2_5555_AAAA, 1'b1, 1'b1);
                if (k == 8) return 36'd2;
                if (k == 9) return dword(34'h3_FFFF_FFFF, 1'b0, 1'b0);
                return dword(34'h0_DEAD_0000 + 34'(k), 1'b1, 1'b1);
            end
            2: if (k == 0) return dword(34'h0_0000_0F0F, 1'b0, 1'b1);
               else if (k == 1) return 36'h1_0000_0000;
               else return pad;
            3: return (k == 0) ? dword(34'h0_0000_00AB, 1'b0, 1'b1) : pad;
            default: return (k == 0) ? dword(34'h0_0000_01CD, 1'b0, 1'b0) : pad;
        endcase
    endfunction

    // R1 slice layout: eight low words, then the nibble word
    function automatic logic [31:0] slice_word(int id, int w);
        int s = w / 9;
        int p = w % 9;
        logic [31:0] nw = '0;
        if (p < 8) return build(id, s * 8 + p)[31:0];
        for (int k = 0; k < 8; k++) nw[31 - 4*k -: 4] = build(id, s * 8 + k)[35:32];
        return nw;
    endfunction

    function automatic int model(int id, int count, longint limit);
        int n = 0;
        bit lenm = 1'b0;
        logic [33:0] s = '0;
        longint run = 0;
        logic [35:0] w;
        for (int i = 0; i < count; i++) begin
            w = build(id, i);
            if (lenm) begin
                run += longint'(w) * 2;
                lenm = 1'b0;
            end else begin
                while (run > 0 && n < limit && n < 256) begin exp_q[n] = s; n++; run--; end
                s = w[33:0];
                run = longint'(w[34]) + 1;
                lenm = w[35];
            end
        end
        if (!lenm)
            while (run > 0 && n < limit && n < 256) begin exp_q[n] = s; n++; run--; end
        return n;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_row(row_t r, string req);
        int total_words = ((int'(r.count) + 7) / 8) * 9;
        int widx = 0;
        int got = 0;
        int cyc = 0;
        int mn;
        mn = model(int'(r.id), int'(r.count), longint'(r.limit));
        @(negedge clk);
        start_i = 1'b1;
        word_count_i = r.count;
        sample_limit_i = r.limit;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (done_o) break;
            if (cyc > 4000) begin
                check(1'b0, req, "row watchdog", 64'(cyc), 64'(4000));
                break;
            end
            out_ready_i = r.bp ? ((cyc % 5) >= 2) : 1'b1;
            if (widx < total_words && !(r.gap && (cyc % 3 == 1))) begin
                in_valid_i = 1'b1;
                in_data_i = slice_word(int'(r.id), widx);
            end else begin
                in_valid_i = 1'b0;
            end
            #1;
            if (in_valid_i && in_ready_o) widx++;
            if (out_valid_o && out_ready_i) begin
                if (got < mn)
                    check(out_data_o == {6'b0, exp_q[got]}, req, "sample (R8 byte order)",
                          64'(out_data_o), 64'(exp_q[got]));
                else
                    check(1'b0, req, "extra sample", 64'(got), 64'(mn));
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid_i = 1'b0;
        out_ready_i = 1'b1;
        check(got == int'(r.exp_n), req, "sample count", 64'(got), 64'(r.exp_n));
        repeat (3) @(negedge clk);
        // R10 done stays high with both handshakes idle
        check(done_o && !out_valid_o && !in_ready_o, "R10", "done held",
              {61'b0, done_o, out_valid_o, in_ready_o}, 64'h4);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            total_cycles++;
            if (total_cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", total_cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11 idle after reset
        check(!in_ready_o && !out_valid_o && !done_o, "R11", "reset idle",
              {61'b0, in_ready_o, out_valid_o, done_o}, 64'h0);
        for (int i = 0; i < NROWS; i++) begin
            case (i)
                0: run_row(ROWS[i], "R1/R2/R3");
                1: run_row(ROWS[i], "R4/R5");
                2: run_row(ROWS[i], "R6");
                3: run_row(ROWS[i], "R6");
                4: run_row(ROWS[i], "R7/R4");
                5: run_row(ROWS[i], "R3/R6");
                6: run_row(ROWS[i], "R9");
                default: run_row(ROWS[i], "R9");
            endcase
        end
        // R9 directed: start in the middle of an active session
        @(negedge clk);
        start_i = 1'b1; word_count_i = 16'd4; sample_limit_i = 32'd100;
        @(negedge clk);
        start_i = 1'b0;
        out_ready_i = 1'b0;
        in_valid_i = 1'b1;
        in_data_i = slice_word(0, 0);
        @(negedge clk);
        start_i = 1'b1; word_count_i = 16'd0; sample_limit_i = 32'd7;
        in_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !out_valid_o && !in_ready_o, "R9", "restart with zero words",
              {61'b0, done_o, out_valid_o, in_ready_o}, 64'h4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule